// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire serial bus read and write a bank of 8-bit configuration registers. The bus lines are sampled on the system clock, which must run at least eight times faster than the serial clock. The block finds START and STOP conditions in the sampled lines and compares the received 7-bit address with its own. Six bits of that address are fixed by a parameter. The seventh bit comes from a strap input, so two copies of the block can share one bus.

After a write address, the first byte loads an 8-bit register pointer, and every later byte is stored at the pointer. After a read address, the block sends the register at the pointer, most significant bit first. The pointer advances after every data byte in both directions, so a burst covers consecutive registers. The block only ever pulls SDA low, through an open-drain enable. The register contents go to the rest of the chip on a flat output bus.

Top module: `cfgbus_slave`

## Requirements
- R1: After reset, register i of the bank holds i XOR 0xA5 (register i is cfg_o[8*i+7:8*i]), and sda_oe is 0.
- R2: The device address is {6'b100110, strap_i}, received MSB first, followed by a direction bit. The block acknowledges (sda_oe high during the ninth SCL pulse) only when the address matches. On a mismatch it does not acknowledge and ignores the rest of the transfer until the next START.
- R3: Bus activity before a START (SDA changing only while SCL is low) is ignored: there is no acknowledge and sda_oe stays 0. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R4: With direction bit 0, the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer. Every byte is acknowledged.
- R5: The pointer increases by one after each data byte. A written byte goes to the pointer value from before that increase, so a burst fills consecutive registers.
- R6: With direction bit 1, the block sends the register at the pointer MSB first and then the following registers on each host acknowledge. For example, 28 reads starting at pointer 0 return registers 0 to 27.
- R7: When the host does not acknowledge a read byte, the block releases SDA and leaves it released until the next START.
- R8: A STOP keeps the pointer, so a read in a later transfer continues where the previous transfer ended.
- R9: A repeated START restarts address reception and keeps the pointer.
- R10: The pointer is 8 bits and wraps from 0xFF to 0x00. A pointer at or above the register count reads as 0x00, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 1 | Least significant device address bit |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_o | output | 8*NUM_REGS | Register bank contents, register i at bits 8*i+7:8*i |

## Verification
At the SCL fall that ends a written data byte, two things happen in the same cycle: the byte is stored and the pointer advances. The write must use the old pointer value. Multi-byte write bursts provoke this case, and the checks read each register on cfg_o against a model that places byte k at start+k. Burst writes that cross the top of the bank and then wrap to 0 provoke the same collision next to the range limit. There the out-of-range byte must leave every register untouched, and the read that follows must return 0x00 and then register 0.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam logic [5:0] OWN_ADDR_HI = 6'b100110;
    localparam logic [BYTE_W-1:0] DEFAULT_MASK = 8'hA5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_HACK
    } state_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } kind_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_evt_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return BYTE_W'(idx) ^ DEFAULT_MASK;
    endfunction

endpackage

// File: rtl/cfgbus_line_cond.sv
module cfgbus_line_cond
    import cfgbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic scl_q;
    logic sda_q;
    logic scl_now;
    logic sda_now;

    assign scl_now = scl_sy[SYNC_STAGES-1];
    assign sda_now = sda_sy[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_now;
            sda_q  <= sda_now;
        end
    end

    always_comb begin
        evt.scl_rise = scl_now & ~scl_q;
        evt.scl_fall = ~scl_now & scl_q;
        evt.start    = scl_now & scl_q & sda_q & ~sda_now;
        evt.stop     = scl_now & scl_q & ~sda_q & sda_now;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
    import cfgbus_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = OWN_ADDR_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wdata,
    output logic              sda_oe
);

    state_t            st;
    kind_t             kind;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-2:0] txsh;
    logic              rw;
    logic              more;
    logic [6:0]        own;
    logic              byte_done;

    assign own       = {ADDR_HI, strap_i};
    assign byte_done = evt.scl_fall && (cnt == 4'd8);
    assign wr_en     = (st == S_RX) && (kind == K_DATA) && byte_done
                       && !evt.start && !evt.stop;
    assign wdata     = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            kind   <= K_ADDR;
            cnt    <= '0;
            shreg  <= '0;
            txsh   <= '0;
            rw     <= 1'b0;
            more   <= 1'b0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (evt.start) begin
            st     <= S_RX;
            kind   <= K_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_RX: begin
                    if (evt.scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], evt.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        unique case (kind)
                            K_ADDR: begin
                                if (shreg[7:1] == own) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    st     <= S_ACK;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            K_PTR: begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                st     <= S_ACK;
                            end
                            default: begin
                                ptr    <= ptr + 1'b1;
                                sda_oe <= 1'b1;
                                st     <= S_ACK;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        if (kind == K_ADDR && rw) begin
                            txsh   <= rdata[BYTE_W-2:0];
                            sda_oe <= ~rdata[BYTE_W-1];
                            st     <= S_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= S_RX;
                            kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (evt.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            st     <= S_HACK;
                        end else begin
                            sda_oe <= ~txsh[BYTE_W-2];
                            txsh   <= {txsh[BYTE_W-3:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                S_HACK: begin
                    if (evt.scl_rise) begin
                        more <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        if (more) begin
                            txsh   <= rdata[BYTE_W-2:0];
                            sda_oe <= ~rdata[BYTE_W-1];
                            cnt    <= '0;
                            st     <= S_TX;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == $past(ptr) + 1'b1));

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !sda_oe);

    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);

    // R9
    restart_keep_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (!sda_oe && ptr == $past(ptr)));

endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PTR_W-1:0]           ptr,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = ({1'b0, ptr} < (PTR_W+1)'(NUM_REGS));
    assign idx      = IDX_W'(ptr);
    assign rdata    = in_range ? regs[idx] : '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= reg_default(g);
            end else if (wr_en && in_range && idx == IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
        assign cfg_o[g*BYTE_W +: BYTE_W] = regs[g];
    end

    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range) |=> (regs[$past(idx)] == $past(wdata)));

    // R10
    range_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(cfg_o));

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter int         NUM_REGS    = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = OWN_ADDR_HI
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       strap_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

    line_evt_t         evt;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rdata;

    cfgbus_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    cfgbus_engine #(.ADDR_HI(ADDR_HI)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .strap_i (strap_i),
        .rdata   (rdata),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .sda_oe  (sda_oe)
    );

    cfgbus_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .ptr   (ptr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata),
        .cfg_o (cfg_o)
    );

endmodule

// File: tb/cfgbus_slave_tb_top.sv
`timescale 1ns/1ps
module cfgbus_slave_tb_top;

    localparam int NREG = 32;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_reg [NREG];
    logic [6:0] own;

    always #2 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;

    cfgbus_slave #(.NUM_REGS(NREG)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe  (sda_oe),
        .cfg_o   (cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        host_sda = 1'b0; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; tick(Q);
            scl = 1'b1;      tick(2*Q);
            scl = 1'b0;      tick(Q);
        end
        host_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0; tick(Q);
        end
        host_sda = ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        host_sda = 1'b1;
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            check(cfg[i*8 +: 8] == exp_reg[i], tag, cfg[i*8 +: 8], exp_reg[i]);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'(i) ^ 8'hA5;
        check_bank("R1 reset value");
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    endtask

    task automatic t_prestart();
        bit a;
        scl = 1'b0; tick(Q);
        send_byte({own, 1'b0}, a);
        check(a == 1'b0, "R3 no ack before START", a, 0);
        check(sda_oe == 1'b0, "R3 sda released before START", sda_oe, 0);
        host_sda = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
    endtask

    task automatic t_write_burst();
        bit a;
        bus_start();
        send_byte({own, 1'b0}, a); check(a, "R2 address ack", a, 1);
        send_byte(8'h03, a);       check(a, "R4 pointer ack", a, 1);
        send_byte(8'h11, a);       check(a, "R4 data ack", a, 1);
        send_byte(8'h22, a);       check(a, "R4 data ack", a, 1);
        send_byte(8'h33, a);       check(a, "R4 data ack", a, 1);
        bus_stop();
        exp_reg[3] = 8'h11; exp_reg[4] = 8'h22; exp_reg[5] = 8'h33;
        check_bank("R5 burst write placement");
        check(sda_oe == 1'b0, "R3 released after STOP", sda_oe, 0);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte({own ^ 7'h01, 1'b0}, a);
        check(a == 1'b0, "R2 mismatch not acked", a, 0);
        send_byte(8'h00, a);
        check(a == 1'b0, "R2 rest ignored", a, 0);
        send_byte(8'h99, a);
        bus_stop();
        check_bank("R2 mismatch leaves bank");
    endtask

    task automatic t_read_after_stop();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({own, 1'b1}, a); check(a, "R6 read address ack", a, 1);
        recv_byte(1'b1, b); check(b == exp_reg[6], "R8 pointer kept over STOP", b, exp_reg[6]);
        recv_byte(1'b0, b); check(b == exp_reg[7], "R6 next register", b, exp_reg[7]);
        recv_byte(1'b1, b); check(b == 8'hFF, "R7 released after NACK", b, 8'hFF);
        check(sda_oe == 1'b0, "R7 sda_oe low after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_long_read();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({own, 1'b0}, a); check(a, "R4 address ack", a, 1);
        send_byte(8'h00, a);       check(a, "R4 pointer ack", a, 1);
        bus_start();
        send_byte({own, 1'b1}, a); check(a, "R9 ack after repeated START", a, 1);
        for (int i = 0; i < 28; i++) begin
            recv_byte(i != 27, b);
            check(b == exp_reg[i], "R6 28-byte read", b, exp_reg[i]);
        end
        bus_stop();
    endtask

    task automatic t_strap();
        bit a;
        strap = 1'b1;
        own = 7'b1001101;
        tick(Q);
        bus_start();
        send_byte({own, 1'b0}, a); check(a, "R2 strap-high address ack", a, 1);
        send_byte(8'h10, a);
        send_byte(8'h5A, a);
        bus_stop();
        exp_reg[16] = 8'h5A;
        check(cfg[16*8 +: 8] == 8'h5A, "R2 strap-high write", cfg[16*8 +: 8], 8'h5A);
        bus_start();
        send_byte({7'b1001100, 1'b0}, a);
        check(a == 1'b0, "R2 old strap address refused", a, 0);
        bus_stop();
    endtask

    task automatic t_range();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({own, 1'b0}, a);
        send_byte(8'h1F, a);
        send_byte(8'hEE, a);
        send_byte(8'h77, a);
        bus_stop();
        exp_reg[31] = 8'hEE;
        check_bank("R10 out-of-range write dropped");
        bus_start();
        send_byte({own, 1'b0}, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte({own, 1'b1}, a);
        recv_byte(1'b1, b); check(b == 8'h00, "R10 out-of-range read", b, 8'h00);
        recv_byte(1'b0, b); check(b == exp_reg[0], "R10 pointer wrap", b, exp_reg[0]);
        bus_stop();
    endtask

    task automatic t_restart();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte({own, 1'b0}, a);
        send_byte(8'h08, a);
        send_byte(8'h44, a);
        exp_reg[8] = 8'h44;
        bus_start();
        send_byte({own, 1'b1}, a); check(a, "R9 repeated START ack", a, 1);
        recv_byte(1'b0, b); check(b == exp_reg[9], "R9 pointer kept over repeated START", b, exp_reg[9]);
        bus_stop();
        check(cfg[8*8 +: 8] == 8'h44, "R5 write before restart", cfg[8*8 +: 8], 8'h44);
    endtask

    initial begin
        own = 7'b1001100;
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset();
        t_prestart();
        t_write_burst();
        t_bad_addr();
        t_read_after_stop();
        t_long_read();
        t_strap();
        t_range();
        t_restart();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule